// File: doc/BRIEF.md
# I2C Slave Receiver with Coded Status Reporting

This block is an I2C-bus slave that only receives. It samples the SCL and SDA lines through synchronizers, finds START and STOP conditions, and compares each address byte with a programmable 7-bit own address. It can also accept the all-zero general call address. Once addressed for a write, it shifts in data bytes MSB first. After each byte it returns ACK or NACK, according to a software-controlled acknowledge-enable bit.

Every meaningful bus event is reported to software as an 8-bit status code, with an event flag. While the flag is up, the block stretches the clock by holding SCL low. Software reads the status and the received byte, chooses the acknowledge policy for the next byte, and then clears the flag to let the bus move on. The bus lines are open-drain, so the block's outputs are drive-low enables.

The controller is a six-state machine:
- IDLE: waits for START.
- ADDR: shifts in the address byte.
- ADDR_ACK: drives the acknowledge bit for the address.
- DATA: shifts in a data byte.
- DATA_ACK: drives or withholds the acknowledge bit for a data byte.
- SKIP: not addressed; ignores the bus until the next START.

Its transitions are:
- START from any state goes to ADDR.
- STOP from any state goes to IDLE.
- ADDR goes to ADDR_ACK on a match with acknowledge enabled, otherwise to SKIP.
- ADDR_ACK goes to DATA.
- DATA goes to DATA_ACK.
- DATA_ACK goes back to DATA after an ACK, or to SKIP after a NACK.

Top module: `i2c_slave_rx`

## Requirements
- R1: After reset the status reads 0xF8, the event flag is 0, the acknowledge-enable bit is 0, the data register is 0x00, and neither SCL nor SDA is driven low.
- R2: Status bits 2:0 always read 0. Status is 0xF8 exactly when the event flag is clear, and every other code sets the flag. Writing 1 to bit 3 of the clear register (wr_sel=1) clears the flag and returns the status to 0xF8.
- R3: Writing 1 to bit 2 of the set register (wr_sel=0) sets acknowledge-enable. Writing 1 to bit 2 of the clear register (wr_sel=1) clears it. A 0 written to either bit has no effect.
- R4: The own-address register (wr_sel=3) holds the 7-bit address in bits 7:1. An address byte equal to that address with the R/W bit 0 is ACKed when acknowledge-enable is 1, and then status 0x60 is posted.
- R5: Bit 0 of the own-address register enables the general call. An address byte of 0x00 is ACKed with status 0x70 only when that bit and acknowledge-enable are both 1. Otherwise it is NACKed and no status is posted.
- R6: An address byte that does not match, has R/W=1, or arrives while acknowledge-enable is 0 is NACKed. No status is posted, and the bytes that follow are ignored until the next START.
- R7: When addressed, a data byte is shifted in MSB first. With acknowledge-enable at 1 it is ACKed, and it appears in the data register with status 0x80 (own address) or 0x90 (general call).
- R8: When addressed, a data byte received with acknowledge-enable at 0 is NACKed, stored, and reported as 0x88 (own address) or 0x98 (general call). The block then stops being addressed.
- R9: A STOP or repeated START while addressed and receiving posts status 0xA0. When the block is not addressed, neither posts a status.
- R10: SCL is held low while the event flag is set and is released once software clears the flag. SDA is never driven while the flag is set.
- R11: A write to the data register (wr_sel=2) takes effect only while the event flag is set. The register otherwise changes only when a byte's status is posted, so it stays stable while the flag remains set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_low_o | output | 1 | Drive SCL low (clock stretch) |
| sda_low_o | output | 1 | Drive SDA low (acknowledge) |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 set, 1 clear, 2 data, 3 own address |
| wr_data | input | 8 | Register write data |
| status_o | output | 8 | Status code |
| data_o | output | 8 | Data register |
| si_o | output | 1 | Event flag |
| aa_o | output | 1 | Acknowledge-enable bit |

## Verification
The checker enforces the following on every cycle:
- The shape of the status byte, with zero low bits and only legal codes on a new event.
- The tie between code 0xF8 and the event flag.
- The effect of the acknowledge-enable set and clear writes.
- SDA never being driven while the clock is stretched.
- A stable data register while the flag is held.

Only the bench's bus scenarios can show the following:
- That the right address and general-call bytes are acknowledged.
- That bytes arrive MSB first and under the correct data code.
- That a NACK drops the block out of the addressed state.
- That STOP and repeated START post 0xA0 only when the block is addressed.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_SKIP
    } rx_state_t;

    localparam logic [7:0] CODE_NONE     = 8'hF8;
    localparam logic [7:0] CODE_OWN_HIT  = 8'h60;
    localparam logic [7:0] CODE_GC_HIT   = 8'h70;
    localparam logic [7:0] CODE_OWN_DACK = 8'h80;
    localparam logic [7:0] CODE_OWN_DNAK = 8'h88;
    localparam logic [7:0] CODE_GC_DACK  = 8'h90;
    localparam logic [7:0] CODE_GC_DNAK  = 8'h98;
    localparam logic [7:0] CODE_ENDED    = 8'hA0;

    localparam logic [1:0] SEL_SET  = 2'd0;
    localparam logic [1:0] SEL_CLR  = 2'd1;
    localparam logic [1:0] SEL_DATA = 2'd2;
    localparam logic [1:0] SEL_OWN  = 2'd3;

    localparam int AA_BIT = 2;
    localparam int SI_BIT = 3;

endpackage

// File: rtl/i2c_rx_sync.sv
module i2c_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_i;
                    sda_pipe <= sda_i;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
                    sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_rx_regs.sv
module i2c_rx_regs
    import i2c_rx_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int ADR_W = BYTE_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              post_valid,
    input  logic [7:0]        post_code,
    input  logic              post_load,
    input  logic [BYTE_W-1:0] post_byte,
    output logic              aa,
    output logic              si,
    output logic [7:0]        status,
    output logic [BYTE_W-1:0] data,
    output logic [ADR_W-1:0]  own_adr,
    output logic              gc_en
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            aa      <= 1'b0;
            si      <= 1'b0;
            status  <= CODE_NONE;
            data    <= '0;
            own_adr <= '0;
            gc_en   <= 1'b0;
        end else begin
            if (wr_en) begin
                unique case (wr_sel)
                    SEL_SET: begin
                        if (wr_data[AA_BIT]) aa <= 1'b1;
                    end
                    SEL_CLR: begin
                        if (wr_data[AA_BIT]) aa <= 1'b0;
                        if (wr_data[SI_BIT]) begin
                            si     <= 1'b0;
                            status <= CODE_NONE;
                        end
                    end
                    SEL_DATA: begin
                        if (si) data <= wr_data;
                    end
                    SEL_OWN: begin
                        own_adr <= wr_data[BYTE_W-1:1];
                        gc_en   <= wr_data[0];
                    end
                    default: ;
                endcase
            end
            if (post_valid) begin
                si     <= 1'b1;
                status <= post_code;
                if (post_load) data <= post_byte;
            end
        end
    end

endmodule

// File: rtl/i2c_rx_fsm.sv
module i2c_rx_fsm
    import i2c_rx_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int ADR_W = BYTE_W - 1,
    localparam int CNT_W = $clog2(BYTE_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sda_s,
    input  logic              aa,
    input  logic [ADR_W-1:0]  own_adr,
    input  logic              gc_en,
    output logic              post_valid,
    output logic [7:0]        post_code,
    output logic              post_load,
    output logic [BYTE_W-1:0] post_byte,
    output logic              sda_low
);
    rx_state_t         st, nxt;
    logic [CNT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic              gc_hit;
    logic              ack_flag;
    logic              byte_done;
    logic              own_hit;
    logic              gc_req;
    logic              take_addr;

    assign byte_done = (bitcnt == CNT_W'(BYTE_W));
    assign own_hit   = (shreg[BYTE_W-1:1] == own_adr) && !shreg[0];
    assign gc_req    = (shreg == '0) && gc_en;
    assign take_addr = aa && (own_hit || gc_req);
    assign post_byte = shreg;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // next state and event posting
    always_comb begin
        nxt        = st;
        post_valid = 1'b0;
        post_code  = CODE_NONE;
        post_load  = 1'b0;
        if (start_det || stop_det) begin
            nxt = start_det ? ST_ADDR : ST_IDLE;
            if (st == ST_DATA) begin
                post_valid = 1'b1;
                post_code  = CODE_ENDED;
            end
        end else begin
            unique case (st)
                ST_IDLE, ST_SKIP: ;
                ST_ADDR: begin
                    if (scl_fall && byte_done)
                        nxt = take_addr ? ST_ADDR_ACK : ST_SKIP;
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        nxt        = ST_DATA;
                        post_valid = 1'b1;
                        post_code  = gc_hit ? CODE_GC_HIT : CODE_OWN_HIT;
                    end
                end
                ST_DATA: begin
                    if (scl_fall && byte_done) nxt = ST_DATA_ACK;
                end
                ST_DATA_ACK: begin
                    if (scl_fall) begin
                        nxt        = ack_flag ? ST_DATA : ST_SKIP;
                        post_valid = 1'b1;
                        post_load  = 1'b1;
                        if (gc_hit) post_code = ack_flag ? CODE_GC_DACK : CODE_GC_DNAK;
                        else        post_code = ack_flag ? CODE_OWN_DACK : CODE_OWN_DNAK;
                    end
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // datapath and bus outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt   <= '0;
            shreg    <= '0;
            gc_hit   <= 1'b0;
            ack_flag <= 1'b0;
            sda_low  <= 1'b0;
        end else if (start_det || stop_det) begin
            bitcnt  <= '0;
            sda_low <= 1'b0;
        end else begin
            unique case (st)
                ST_ADDR, ST_DATA: begin
                    if (scl_rise && !byte_done) begin
                        shreg  <= {shreg[BYTE_W-2:0], sda_s};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (scl_fall && byte_done) begin
                        bitcnt <= '0;
                        if (st == ST_ADDR) begin
                            sda_low <= take_addr;
                            gc_hit  <= gc_req;
                        end else begin
                            sda_low  <= aa;
                            ack_flag <= aa;
                        end
                    end
                end
                ST_ADDR_ACK, ST_DATA_ACK: begin
                    if (scl_fall) sda_low <= 1'b0;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/i2c_slave_rx.sv
module i2c_slave_rx
    import i2c_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int BYTE_W      = 8,
    localparam int ADR_W      = BYTE_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_low_o,
    output logic              sda_low_o,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [7:0]        status_o,
    output logic [BYTE_W-1:0] data_o,
    output logic              si_o,
    output logic              aa_o
);
    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              post_valid, post_load;
    logic [7:0]        post_code;
    logic [BYTE_W-1:0] post_byte;
    logic [ADR_W-1:0]  own_adr;
    logic              gc_en;
    logic              aa, si;

    i2c_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_rx_fsm #(.BYTE_W(BYTE_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
        .aa(aa), .own_adr(own_adr), .gc_en(gc_en),
        .post_valid(post_valid), .post_code(post_code), .post_load(post_load),
        .post_byte(post_byte), .sda_low(sda_low_o)
    );

    i2c_rx_regs #(.BYTE_W(BYTE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .post_valid(post_valid), .post_code(post_code), .post_load(post_load),
        .post_byte(post_byte), .aa(aa), .si(si), .status(status_o), .data(data_o),
        .own_adr(own_adr), .gc_en(gc_en)
    );

    assign scl_low_o = si;
    assign si_o      = si;
    assign aa_o      = aa;

endmodule

// File: rtl/i2c_rx_chk.sv
module i2c_rx_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic [BYTE_W-1:0] wr_data,
    input logic [7:0]        status_o,
    input logic [BYTE_W-1:0] data_o,
    input logic              si_o,
    input logic              aa_o,
    input logic              sda_low_o
);
    AST_STATUS_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[2:0] == 3'b000); // R2
    AST_NONE_MEANS_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == 8'hF8) == !si_o); // R2
    AST_LEGAL_EVENT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(si_o) |-> (status_o inside {8'h60, 8'h70, 8'h80, 8'h88, 8'h90, 8'h98, 8'hA0})); // R2
    AST_AA_SET_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0 && wr_data[2]) |=> aa_o); // R3
    AST_AA_CLR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd1 && wr_data[2]) |=> !aa_o); // R3
    AST_NO_ACK_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        si_o |-> !sda_low_o); // R10
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (si_o && $past(si_o) && !$past(wr_en && wr_sel == 2'd2)) |-> $stable(data_o)); // R11
endmodule

bind i2c_slave_rx i2c_rx_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .status_o(status_o), .data_o(data_o), .si_o(si_o), .aa_o(aa_o),
    .sda_low_o(sda_low_o)
);

// File: tb/sim_i2c_slave_rx.sv
`timescale 1ns/1ps
module sim_i2c_slave_rx;
    localparam int T = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl_low = 1'b0;
    logic       m_sda_low = 1'b0;
    logic       scl_line, sda_line;
    logic       scl_low_o, sda_low_o;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] status_o, data_o;
    logic       si_o, aa_o;
    int         n_tests = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    assign scl_line = ~(m_scl_low | scl_low_o);
    assign sda_line = ~(m_sda_low | sda_low_o);

    i2c_slave_rx u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .scl_low_o(scl_low_o), .sda_low_o(sda_low_o),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .status_o(status_o), .data_o(data_o), .si_o(si_o), .aa_o(aa_o)
    );

    function automatic logic [7:0] exp_addr_code(bit gc);
        return gc ? 8'h70 : 8'h60;
    endfunction

    function automatic logic [7:0] exp_data_code(bit gc, bit ack);
        if (gc) return ack ? 8'h90 : 8'h98;
        return ack ? 8'h80 : 8'h88;
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(bit ok, string req, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(logic [1:0] sel, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        tick(1);
    endtask

    task automatic wait_high();
        while (!scl_line) tick(1);
    endtask

    task automatic bus_start();
        m_sda_low = 1'b0; m_scl_low = 1'b0; tick(T);
        m_sda_low = 1'b1; tick(T);
        m_scl_low = 1'b1; tick(T);
    endtask

    task automatic send_bit(bit b);
        m_sda_low = !b; tick(T);
        m_scl_low = 1'b0; wait_high(); tick(T);
        m_scl_low = 1'b1; tick(T);
    endtask

    task automatic send_byte(logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        m_sda_low = 1'b0; tick(T);
        m_scl_low = 1'b0; wait_high(); tick(T/2);
        acked = !sda_line; tick(T/2);
        m_scl_low = 1'b1; tick(T);
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1; tick(T);
        m_scl_low = 1'b0; wait_high(); tick(T);
        m_sda_low = 1'b0; tick(T);
    endtask

    task automatic bus_rstart();
        m_sda_low = 1'b0; tick(T);
        m_scl_low = 1'b0; wait_high(); tick(T);
        m_sda_low = 1'b1; tick(T);
        m_scl_low = 1'b1; tick(T);
    endtask

    // check a posted event, then release it through the clear register
    task automatic sw_event(logic [7:0] code, string req);
        chk(si_o == 1'b1, req, si_o, 1);
        chk(status_o == code, req, status_o, code);
        chk(scl_low_o == 1'b1, "R10 hold", scl_low_o, 1);
        reg_wr(2'd1, 8'h08);
        chk(si_o == 1'b0 && status_o == 8'hF8, "R2 clear", status_o, 8'hF8);
        chk(scl_low_o == 1'b0, "R10 release", scl_low_o, 0);
    endtask

    // kind: 0 own write, 1 own read, 2 general call, 3 other address
    task automatic run_txn(logic [6:0] own, bit gcen, int kind, bit aa_addr,
                           int nbytes, logic [3:0] aa_mask, bit end_rs);
        logic [7:0] ab;
        logic [6:0] other;
        bit         ack, hit, live, gc;
        string      rq;
        other = own ^ 7'(1 + $urandom % 126);
        if (other == 7'd0) other = own ^ 7'h7F;
        reg_wr(2'd3, {own, gcen});
        reg_wr(aa_addr ? 2'd0 : 2'd1, 8'h04);
        unique case (kind)
            0: ab = {own, 1'b0};
            1: ab = {own, 1'b1};
            2: ab = 8'h00;
            default: ab = {other, 1'b0};
        endcase
        gc  = (kind == 2);
        hit = aa_addr && (kind == 0 || (kind == 2 && gcen));
        rq  = !aa_addr ? "R6 aa0" : (kind == 0) ? "R4" : (kind == 2) ? "R5" : "R6";
        bus_start();
        send_byte(ab, ack);
        chk(ack == hit, rq, ack, hit);
        if (hit) sw_event(exp_addr_code(gc), rq);
        else chk(si_o == 1'b0, rq, si_o, 0);
        live = hit;
        for (int j = 0; j < nbytes; j++) begin
            logic [7:0] d;
            bit         a;
            d = 8'($urandom);
            a = aa_mask[j];
            reg_wr(a ? 2'd0 : 2'd1, 8'h04);
            send_byte(d, ack);
            if (live) begin
                chk(ack == a, a ? "R7 ack" : "R8 nack", ack, a);
                chk(data_o == d, "R7 data", data_o, d);
                sw_event(exp_data_code(gc, a), a ? "R7 code" : "R8 code");
                live = a;
            end else begin
                chk(!ack && !si_o, "R6 ignored", {ack, si_o}, 0);
            end
        end
        if (end_rs) bus_rstart();
        else bus_stop();
        if (live) sw_event(8'hA0, "R9");
        else chk(si_o == 1'b0, "R9 quiet", si_o, 0);
        if (end_rs) begin
            bus_stop();
            chk(si_o == 1'b0, "R9 after rstart", si_o, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        bit ack;
        void'($urandom(32'h1C2B));
        tick(4);
        rst_n = 1'b1;
        tick(2);
        // R1 reset state
        chk(status_o == 8'hF8, "R1 status", status_o, 8'hF8);
        chk(!si_o && !aa_o && data_o == 8'h00, "R1 flags", {si_o, aa_o, data_o}, 0);
        chk(!scl_low_o && !sda_low_o, "R1 bus", {scl_low_o, sda_low_o}, 0);

        // R3 set/clear semantics
        reg_wr(2'd0, 8'hFB);
        chk(aa_o == 1'b0, "R3 zero set", aa_o, 0);
        reg_wr(2'd0, 8'h04);
        chk(aa_o == 1'b1, "R3 set", aa_o, 1);
        reg_wr(2'd1, 8'hFB);
        chk(aa_o == 1'b1, "R3 zero clear", aa_o, 1);
        reg_wr(2'd1, 8'h04);
        chk(aa_o == 1'b0, "R3 clear", aa_o, 0);

        // R11 write ignored while flag clear
        reg_wr(2'd2, 8'h77);
        chk(data_o == 8'h00, "R11 write no flag", data_o, 0);

        // directed own address transaction
        reg_wr(2'd3, {7'h3A, 1'b0});
        reg_wr(2'd0, 8'h04);
        bus_start();
        send_byte({7'h3A, 1'b0}, ack);
        chk(ack, "R4 ack", ack, 1);
        sw_event(8'h60, "R4");
        send_byte(8'hA5, ack);
        chk(ack, "R7 ack", ack, 1);
        chk(data_o == 8'hA5, "R7 msb first", data_o, 8'hA5);
        chk(status_o == 8'h80, "R7 code", status_o, 8'h80);
        tick(20);
        chk(data_o == 8'hA5, "R11 stable", data_o, 8'hA5);
        reg_wr(2'd2, 8'h5A);
        chk(data_o == 8'h5A, "R11 write with flag", data_o, 8'h5A);
        reg_wr(2'd1, 8'h08);
        reg_wr(2'd2, 8'hC3);
        chk(data_o == 8'h5A, "R11 write dropped", data_o, 8'h5A);
        reg_wr(2'd1, 8'h04);
        send_byte(8'h3C, ack);
        chk(!ack, "R8 nack", ack, 0);
        chk(data_o == 8'h3C, "R8 data", data_o, 8'h3C);
        sw_event(8'h88, "R8");
        reg_wr(2'd0, 8'h04);
        send_byte(8'h99, ack);
        chk(!ack && !si_o, "R6 after nack", {ack, si_o}, 0);
        bus_stop();
        chk(!si_o, "R9 not addressed", si_o, 0);

        // general call directed cases
        run_txn(7'h12, 1'b0, 2, 1'b1, 1, 4'hF, 1'b0);
        run_txn(7'h12, 1'b1, 2, 1'b1, 2, 4'b0001, 1'b0);
        run_txn(7'h12, 1'b1, 2, 1'b1, 1, 4'hF, 1'b1);
        run_txn(7'h12, 1'b0, 0, 1'b0, 1, 4'hF, 1'b0);
        run_txn(7'h12, 1'b0, 1, 1'b1, 1, 4'hF, 1'b0);

        // constrained random transactions
        for (int k = 0; k < 40; k++) begin
            logic [6:0] own;
            own = 7'(1 + $urandom % 126);
            run_txn(own, 1'($urandom), int'($urandom % 4), ($urandom % 5) != 0,
                    1 + int'($urandom % 3), 4'($urandom | 4'b0001), 1'($urandom));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule